// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches sixteen asynchronous external interrupt pins and turns selected edges on them into sticky per-line flags. Each pin is first brought into the clock domain through a two-stage synchroniser. A later stage compares the current synchronised sample with the previous one. A rising transition counts as an event when that line's rising-edge enable is set. A falling transition counts when its falling-edge enable is set. With both enables set, either transition counts.

The flags are masked by a per-line request enable and then grouped onto the request outputs. Lines 4 to 15 share one ORed interrupt request. Lines 2 and 3 each have an interrupt request of their own. Lines 0 and 1 each go either to an interrupt request or to a DMA transfer request, chosen per line. An event that arrives while its line's flag is still set records an overrun. The overrun flags, masked by a per-line overrun enable, are ORed into one overrun request.

Software uses a small register bus to program the block and to acknowledge flags. The DMA pair for each line works as a valid/ready handshake. `dma_req` stays high until the DMA side raises `dma_ack` in the same cycle, and that transfer clears the flag. An `dma_ack` that arrives while its `dma_req` is low is ignored.

Top module: `xirq_edge_ctrl`

## Requirements
- R1: After reset all seven registers read 0 and every request output is low.
- R2: A 0-to-1 change on pin n with rising enable bit n set makes status flag bit n read 1. The flag and the outputs it drives show the change in the third cycle after the pin changes.
- R3: A 1-to-0 change on pin n with falling enable bit n set sets flag bit n with the same latency. With both enables set, each direction sets the flag.
- R4: A pin transition whose direction is not enabled leaves the flag at 0 and the outputs low.
- R5: Writing to the flag register clears each bit written as 1 and keeps each bit written as 0. When an event and a clearing write reach the same line in the same cycle, the flag stays set.
- R6: An event on a line whose flag is already set sets overrun bit n. `irq_ovr` is the OR of overrun bits ANDed with overrun enable bits. Overrun bits clear on a write of 1, and a write of 0 has no effect on them.
- R7: `irq_upper` is high when any line from 4 to 15 has both its flag and its request enable set.
- R8: `irq_solo[0]` follows line 2 and `irq_solo[1]` follows line 3, each being flag AND request enable.
- R9: For line k in {0,1}, the value of flag AND request enable goes to `dma_req[k]` when DMA select bit k is 1, and to `irq_low[k]` when it is 0. The other output of the pair stays low.
- R10: A cycle with `dma_req[k]` and `dma_ack[k]` both high clears flag k at that clock edge. `dma_ack[k]` has no effect while `dma_req[k]` is low.
- R11: Registers are addressed by `bus_addr`: 0 rising enable, 1 falling enable, 2 flags, 3 overrun enable, 4 overrun flags, 5 request enable, 6 DMA select (bits 1:0, upper bits read 0). Bit n belongs to line n. Read data appears on `bus_rdata` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| irq_low | output | 2 | Interrupt requests of lines 0 and 1 |
| irq_solo | output | 2 | Interrupt requests of lines 2 and 3 |
| irq_upper | output | 1 | Combined interrupt request of lines 4 to 15 |
| irq_ovr | output | 1 | Combined overrun request |
| dma_req | output | 2 | DMA transfer requests of lines 0 and 1 |
| dma_ack | input | 2 | DMA acknowledgements for lines 0 and 1 |

## Verification
The path from a pin to its flag contains three registers: two synchroniser stages and the register that captures the flag. A pin change driven just after edge N is therefore visible on the flag and on its request outputs after edge N+3. The bench drives pins on a falling clock edge and waits three falling edges before it samples. A write or a DMA acknowledgement acts on the next rising edge, so its result is sampled at the following falling edge. Read data is taken one falling edge after `bus_rd` is raised. To make a clearing write and an event meet in the same cycle, the bench issues the write exactly two falling edges after the pin change.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_RISE_EN = 3'd0,
    A_FALL_EN = 3'd1,
    A_FLAG    = 3'd2,
    A_OVR_EN  = 3'd3,
    A_OVR     = 3'd4,
    A_REQ_EN  = 3'd5,
    A_DMA_SEL = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/xirq_edge_det.sv
module xirq_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  // rising: now high, was low; falling: now low, was high
  assign edge_hit = (smp & ~prev_q & rise_en) | (~smp & prev_q & fall_en);
endmodule

// File: rtl/xirq_flag_bank.sv
module xirq_flag_bank #(
  parameter int unsigned W         = 16,
  parameter int unsigned DMA_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         edge_hit,
  input  logic [W-1:0]         clr_flag,
  input  logic [W-1:0]         clr_ovr,
  input  logic [DMA_LINES-1:0] dma_clr,
  output logic [W-1:0]         flag_q,
  output logic [W-1:0]         ovr_q
);
  localparam int unsigned PAD = W - DMA_LINES;

  logic [W-1:0] dma_wide;
  logic [W-1:0] flag_d;
  logic [W-1:0] ovr_d;

  assign dma_wide = {{PAD{1'b0}}, dma_clr};

  always_comb begin
    // a fresh event overrides any clear arriving in the same cycle
    flag_d = (flag_q & ~(clr_flag | dma_wide)) | edge_hit;
    ovr_d  = (ovr_q & ~clr_ovr) | (edge_hit & flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ovr_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ovr_q  <= ovr_d;
    end
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned DMA_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  input  logic [W-1:0]         flag_q,
  input  logic [W-1:0]         ovr_q,
  output logic [W-1:0]         rise_en,
  output logic [W-1:0]         fall_en,
  output logic [W-1:0]         ovr_en,
  output logic [W-1:0]         req_en,
  output logic [DMA_LINES-1:0] dma_sel,
  output logic [W-1:0]         clr_flag,
  output logic [W-1:0]         clr_ovr
);
  localparam int unsigned PAD = W - DMA_LINES;

  reg_addr_e    addr;
  logic [W-1:0] rd_mux;

  assign addr = reg_addr_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      ovr_en  <= '0;
      req_en  <= '0;
      dma_sel <= '0;
    end else if (bus_wr) begin
      case (addr)
        A_RISE_EN: rise_en <= bus_wdata;
        A_FALL_EN: fall_en <= bus_wdata;
        A_OVR_EN:  ovr_en  <= bus_wdata;
        A_REQ_EN:  req_en  <= bus_wdata;
        A_DMA_SEL: dma_sel <= bus_wdata[DMA_LINES-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_flag = '0;
    clr_ovr  = '0;
    if (bus_wr && addr == A_FLAG) clr_flag = bus_wdata;
    if (bus_wr && addr == A_OVR)  clr_ovr  = bus_wdata;
  end

  always_comb begin
    case (addr)
      A_RISE_EN: rd_mux = rise_en;
      A_FALL_EN: rd_mux = fall_en;
      A_FLAG:    rd_mux = flag_q;
      A_OVR_EN:  rd_mux = ovr_en;
      A_OVR:     rd_mux = ovr_q;
      A_REQ_EN:  rd_mux = req_en;
      A_DMA_SEL: rd_mux = {{PAD{1'b0}}, dma_sel};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/xirq_req_route.sv
module xirq_req_route #(
  parameter int unsigned W          = 16,
  parameter int unsigned DMA_LINES  = 2,
  parameter int unsigned UPPER_BASE = 4
) (
  input  logic [W-1:0]                     flag_q,
  input  logic [W-1:0]                     ovr_q,
  input  logic [W-1:0]                     req_en,
  input  logic [W-1:0]                     ovr_en,
  input  logic [DMA_LINES-1:0]             dma_sel,
  input  logic [DMA_LINES-1:0]             dma_ack,
  output logic [DMA_LINES-1:0]             irq_low,
  output logic [DMA_LINES-1:0]             dma_req,
  output logic [DMA_LINES-1:0]             dma_clr,
  output logic [UPPER_BASE-DMA_LINES-1:0]  irq_solo,
  output logic                             irq_upper,
  output logic                             irq_ovr
);
  logic [W-1:0] live;

  assign live = flag_q & req_en;

  for (genvar g = 0; g < DMA_LINES; g++) begin : g_dma
    assign dma_req[g] = live[g] & dma_sel[g];
    assign irq_low[g] = live[g] & ~dma_sel[g];
    assign dma_clr[g] = dma_req[g] & dma_ack[g];
  end

  assign irq_solo  = live[UPPER_BASE-1:DMA_LINES];
  assign irq_upper = |live[W-1:UPPER_BASE];
  assign irq_ovr   = |(ovr_q & ovr_en);
endmodule

// File: rtl/xirq_edge_ctrl.sv
module xirq_edge_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned DMA_LINES   = 2,
  parameter int unsigned UPPER_BASE  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            pin_in,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [REG_AW-1:0]               bus_addr,
  input  logic [NUM_LINES-1:0]            bus_wdata,
  output logic [NUM_LINES-1:0]            bus_rdata,
  output logic [DMA_LINES-1:0]            irq_low,
  output logic [UPPER_BASE-DMA_LINES-1:0] irq_solo,
  output logic                            irq_upper,
  output logic                            irq_ovr,
  output logic [DMA_LINES-1:0]            dma_req,
  input  logic [DMA_LINES-1:0]            dma_ack
);
  logic [NUM_LINES-1:0] smp;
  logic [NUM_LINES-1:0] rise_en, fall_en, ovr_en, req_en;
  logic [NUM_LINES-1:0] edge_hit;
  logic [NUM_LINES-1:0] flag_q, ovr_q;
  logic [NUM_LINES-1:0] clr_flag, clr_ovr;
  logic [DMA_LINES-1:0] dma_sel, dma_clr;

  xirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(smp)
  );

  xirq_edge_det #(.W(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp(smp),
    .rise_en(rise_en), .fall_en(fall_en), .edge_hit(edge_hit)
  );

  xirq_flag_bank #(.W(NUM_LINES), .DMA_LINES(DMA_LINES)) u_flags (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit),
    .clr_flag(clr_flag), .clr_ovr(clr_ovr), .dma_clr(dma_clr),
    .flag_q(flag_q), .ovr_q(ovr_q)
  );

  xirq_regs #(.W(NUM_LINES), .DMA_LINES(DMA_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_q(flag_q), .ovr_q(ovr_q),
    .rise_en(rise_en), .fall_en(fall_en), .ovr_en(ovr_en),
    .req_en(req_en), .dma_sel(dma_sel),
    .clr_flag(clr_flag), .clr_ovr(clr_ovr)
  );

  xirq_req_route #(.W(NUM_LINES), .DMA_LINES(DMA_LINES),
                   .UPPER_BASE(UPPER_BASE)) u_route (
    .flag_q(flag_q), .ovr_q(ovr_q), .req_en(req_en), .ovr_en(ovr_en),
    .dma_sel(dma_sel), .dma_ack(dma_ack),
    .irq_low(irq_low), .dma_req(dma_req), .dma_clr(dma_clr),
    .irq_solo(irq_solo), .irq_upper(irq_upper), .irq_ovr(irq_ovr)
  );
endmodule

// File: rtl/xirq_edge_ctrl_chk.sv
module xirq_edge_ctrl_chk #(
  parameter int unsigned W         = 16,
  parameter int unsigned DMA_LINES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [W-1:0]         flag_q,
  input logic [W-1:0]         ovr_q,
  input logic [W-1:0]         edge_hit,
  input logic [W-1:0]         rise_en,
  input logic [W-1:0]         fall_en,
  input logic [DMA_LINES-1:0] dma_req,
  input logic [DMA_LINES-1:0] irq_low,
  input logic [DMA_LINES-1:0] dma_ack
);
  // R2
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0));

  // R4
  edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~(rise_en | fall_en)) == '0));

  // R6
  ovr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_q & ~$past(ovr_q) & ~($past(edge_hit) & $past(flag_q))) == '0));

  // R9
  dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_req & irq_low) == '0));

  for (genvar g = 0; g < DMA_LINES; g++) begin : g_ack
    // R10
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dma_ack[g] & dma_req[g]) && !$past(edge_hit[g])) |-> !flag_q[g]);
  end
endmodule

bind xirq_edge_ctrl xirq_edge_ctrl_chk #(.W(NUM_LINES), .DMA_LINES(DMA_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .ovr_q(ovr_q),
  .edge_hit(edge_hit), .rise_en(rise_en), .fall_en(fall_en),
  .dma_req(dma_req), .irq_low(irq_low), .dma_ack(dma_ack)
);

// File: tb/xirq_edge_ctrl_bench.sv
`timescale 1ns/1ps
module xirq_edge_ctrl_bench;
  localparam logic [2:0] RA_RISE = 3'd0, RA_FALL = 3'd1, RA_FLAG = 3'd2,
                         RA_OVRE = 3'd3, RA_OVR = 3'd4, RA_REQE = 3'd5,
                         RA_DSEL = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin_in;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  irq_low, irq_solo, dma_req, dma_ack;
  logic        irq_upper, irq_ovr;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  xirq_edge_ctrl u_xirq_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_low(irq_low), .irq_solo(irq_solo), .irq_upper(irq_upper),
    .irq_ovr(irq_ovr), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  function automatic logic [6:0] outs();
    return {irq_upper, irq_solo, irq_low, dma_req};
  endfunction

  // expected output vector {upper, solo[1:0], low[1:0], dma[1:0]} for one line
  function automatic logic [6:0] line_outs(int l);
    return (l < 4) ? 7'(1 << (l + 2)) : 7'h40;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; pin_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; dma_ack = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 32'(outs()), 32'h0);
    chk("R1 irq_ovr", 32'(irq_ovr), 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 register", 32'(v), 32'h0);
    end

    // R11 readback
    wr(RA_RISE, 16'hA5C3); rd(RA_RISE, v); chk("R11 rise", 32'(v), 32'hA5C3);
    wr(RA_FALL, 16'h3C5A); rd(RA_FALL, v); chk("R11 fall", 32'(v), 32'h3C5A);
    wr(RA_OVRE, 16'h0F0F); rd(RA_OVRE, v); chk("R11 ovr_en", 32'(v), 32'h0F0F);
    wr(RA_REQE, 16'h1234); rd(RA_REQE, v); chk("R11 req_en", 32'(v), 32'h1234);
    wr(RA_DSEL, 16'hFFFF); rd(RA_DSEL, v); chk("R11 dma_sel", 32'(v), 32'h0003);
    wr(RA_RISE, 0); wr(RA_FALL, 0); wr(RA_OVRE, 0); wr(RA_DSEL, 0);
    wr(RA_REQE, 16'hFFFF);

    // R2 R3 R4 sweep: every line, every enable combination, both directions
    for (int l = 0; l < 16; l++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [15:0] bit_l;
        bit_l = 16'(1 << l);
        wr(RA_RISE, cfg[0] ? bit_l : 16'h0);
        wr(RA_FALL, cfg[1] ? bit_l : 16'h0);
        pin_in[l] = 1'b1;
        settle();
        chk("R2 R4 rise outputs", 32'(outs()), cfg[0] ? 32'(line_outs(l)) : 32'h0);
        rd(RA_FLAG, v);
        chk("R2 R4 rise flag", 32'(v), cfg[0] ? 32'(bit_l) : 32'h0);
        wr(RA_FLAG, 16'hFFFF);
        pin_in[l] = 1'b0;
        settle();
        chk("R3 R4 fall outputs", 32'(outs()), cfg[1] ? 32'(line_outs(l)) : 32'h0);
        rd(RA_FLAG, v);
        chk("R3 R4 fall flag", 32'(v), cfg[1] ? 32'(bit_l) : 32'h0);
        wr(RA_FLAG, 16'hFFFF);
      end
    end

    // R5 R6: clear colliding with a new event, overrun capture
    wr(RA_RISE, 16'h0020); wr(RA_FALL, 16'h0020);
    pin_in[5] = 1'b1;
    settle();
    wr(RA_FLAG, 16'h0000);
    rd(RA_FLAG, v); chk("R5 write 0 keeps flag", 32'(v), 32'h0020);
    pin_in[5] = 1'b0;
    repeat (2) @(negedge clk);
    wr(RA_FLAG, 16'h0020);
    rd(RA_FLAG, v); chk("R5 event beats clear", 32'(v), 32'h0020);
    rd(RA_OVR, v);  chk("R6 overrun set", 32'(v), 32'h0020);
    chk("R6 masked overrun", 32'(irq_ovr), 32'h0);
    wr(RA_OVRE, 16'h0020);
    chk("R6 enabled overrun", 32'(irq_ovr), 32'h1);
    wr(RA_OVR, 16'h0000);
    chk("R6 write 0 keeps overrun", 32'(irq_ovr), 32'h1);
    wr(RA_OVR, 16'h0020);
    chk("R6 overrun cleared", 32'(irq_ovr), 32'h0);
    wr(RA_FLAG, 16'h0020);
    rd(RA_FLAG, v); chk("R5 write 1 clears", 32'(v), 32'h0);
    wr(RA_OVRE, 0); wr(RA_FALL, 0);

    // R7 upper group OR and request-enable mask
    wr(RA_RISE, 16'h1040);
    pin_in[6] = 1'b1; pin_in[12] = 1'b1;
    settle();
    chk("R7 two upper lines", 32'(irq_upper), 32'h1);
    wr(RA_FLAG, 16'h0040);
    chk("R7 one upper line left", 32'(irq_upper), 32'h1);
    wr(RA_REQE, 16'hEFFF);
    chk("R7 masked by request enable", 32'(irq_upper), 32'h0);
    rd(RA_FLAG, v); chk("R7 flag kept under mask", 32'(v), 32'h1000);
    wr(RA_REQE, 16'hFFFF);
    chk("R7 unmasked again", 32'(irq_upper), 32'h1);
    wr(RA_FLAG, 16'hFFFF);
    pin_in = '0;

    // R8 individual lines 2 and 3
    wr(RA_RISE, 16'h000C);
    pin_in[2] = 1'b1; pin_in[3] = 1'b1;
    settle();
    chk("R8 both solo", 32'(irq_solo), 32'h3);
    wr(RA_REQE, 16'hFFF7);
    chk("R8 line 3 masked", 32'(irq_solo), 32'h1);
    wr(RA_REQE, 16'hFFFF);
    wr(RA_FLAG, 16'hFFFF);
    pin_in = '0;

    // R9 R10 DMA steering and acknowledge
    wr(RA_RISE, 16'h0003); wr(RA_DSEL, 16'h0001);
    pin_in[0] = 1'b1; pin_in[1] = 1'b1;
    settle();
    chk("R9 dma_req line 0", 32'(dma_req), 32'h1);
    chk("R9 irq_low line 1", 32'(irq_low), 32'h2);
    dma_ack = 2'b10;
    @(negedge clk);
    dma_ack = 2'b00;
    rd(RA_FLAG, v); chk("R10 ack without req ignored", 32'(v), 32'h0003);
    dma_ack = 2'b01;
    @(negedge clk);
    dma_ack = 2'b00;
    chk("R10 dma_req dropped", 32'(dma_req), 32'h0);
    rd(RA_FLAG, v); chk("R10 flag cleared by ack", 32'(v), 32'h0002);
    wr(RA_DSEL, 16'h0003);
    chk("R9 line 1 to dma", 32'(dma_req), 32'h2);
    chk("R9 line 1 irq off", 32'(irq_low), 32'h0);
    wr(RA_REQE, 16'hFFFD);
    chk("R9 dma masked", 32'(dma_req), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule